// File: doc/BRIEF.md
# Self-Supply and Overload Latch Supervisor

This block is the digital supervisor of an off-line switching controller that draws its own supply from the high-voltage rail. It receives already-resolved comparator flags for the supply rail, the feedback node and the die temperature. From these it drives the enable of the high-voltage start-up current source and the run enable of the PWM sequencer. It also reports whether overload protection is armed and whether a fault has been latched.

The supervisor has three named states, each one-hot encoded. **START** (`SUP_START`) is the power-on state: the source charges the supply and no pulses are allowed. **RUN** (`SUP_RUN`) is regulation: pulses are allowed and the source cycles with its hysteresis. **LATCH** (`SUP_LATCH`) is latched-off: pulses are stopped for good while the source keeps the supply cycling. The transitions are as follows. *Startup done* (START to RUN) fires on the first time the supply passes its upper threshold. *Overload trip* (RUN to LATCH) fires when an armed overload persists for the filter window. *Supply collapse* (any state to START) fires on the near-zero supply flag or on reset. *Illegal recovery* (any non one-hot code to START) covers a corrupted state register.

Protection is armed only once the supply first falls to its lower threshold after startup. This keeps the open-loop feedback level that appears while the output capacitor charges from tripping the latch.

Top module: `supply_fault_supervisor`

## Requirements
- R1: After reset, and while no upper-threshold event has been seen, src_en=1, run_en=0, armed=0 and latched=0.
- R2: src_en is a registered hysteresis bit, updated one clock after the flags are sampled. It becomes 0 when vcc_above_hi=1. It becomes 1 when vcc_below_lo=1 and vcc_above_hi=0. It holds its value when both flags are 0. vcc_above_hi wins when both flags are 1.
- R3: In START, a sampled vcc_above_hi=1 moves the block to RUN. From the next clock, run_en=1 as long as over_temp=0.
- R4: In RUN, run_en stays 1 in both phases of the source (src_en 0 or 1).
- R5: armed is set one clock after vcc_below_lo=1 is sampled in RUN. Before that, fb_open_loop has no effect on latched or run_en, however long it is held. armed never sets in START.
- R6: When armed=1 in RUN, fb_open_loop=1 sampled on FILT_CYCLES consecutive clocks sets latched=1 one clock after the last of them. A shorter burst leaves latched=0 and restarts the count.
- R7: While latched=1, run_en=0 and latched holds whatever the values of fb_open_loop, vcc_above_hi and vcc_below_lo. src_en keeps following R2.
- R8: vcc_below_por=1 acts as a synchronous reset that takes precedence over all other inputs. One clock later it gives src_en=1, run_en=0, armed=0, latched=0, and the START state.
- R9: over_temp=1 forces run_en=0 combinationally, in the same cycle, without changing the state or armed. Clearing it restores run_en in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vcc_above_hi | input | 1 | Supply at or above the upper threshold |
| vcc_below_lo | input | 1 | Supply at or below the lower threshold |
| vcc_below_por | input | 1 | Supply near zero; returns block to power-on state |
| fb_open_loop | input | 1 | Feedback node at its open-loop level (overload) |
| over_temp | input | 1 | Die over-temperature, hysteresis already applied |
| src_en | output | 1 | Start-up current source enable |
| run_en | output | 1 | PWM sequencer run enable |
| armed | output | 1 | Overload protection armed |
| latched | output | 1 | Overload fault latched |

## Verification
The bench builds the block with FILT_CYCLES=4. This makes every overload burst length up to and including the tripping one reachable within a few cycles, so burst lengths 1 through 4 are swept and only the last is expected to latch. The source hysteresis is swept over all four flag combinations from both prior source states. The bench also covers reset precedence over a simultaneous upper-threshold event, and the combinational over-temperature gate observed before and after a clock edge.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    typedef enum logic [2:0] {
        SUP_START = 3'b001,
        SUP_RUN   = 3'b010,
        SUP_LATCH = 3'b100
    } sup_state_e;
endpackage

// File: rtl/sfs_source_hyst.sv
module sfs_source_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic por,
    input  logic hi,
    input  logic lo,
    output logic src_en
);
    logic src_q;

    // upper threshold dominates; hold between thresholds
    always_ff @(posedge clk) begin
        if (!rst_n || por)
            src_q <= 1'b1;
        else if (hi)
            src_q <= 1'b0;
        else if (lo)
            src_q <= 1'b1;
    end

    assign src_en = src_q;
endmodule

// File: rtl/sfs_overload_filter.sv
module sfs_overload_filter #(
    parameter int FILT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por,
    input  logic enable,
    input  logic fb,
    output logic hit
);
    localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          active;

    assign active = enable && fb;
    assign hit    = active && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || por || !active)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sfs_mode_fsm.sv
module sfs_mode_fsm
    import sfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic por,
    input  logic hi,
    input  logic lo,
    input  logic trip,
    input  logic ot,
    output logic run_en,
    output logic armed,
    output logic latched,
    output logic in_run
);
    sup_state_e state_q, state_d;
    logic       armed_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || por)
            state_q <= SUP_START;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUP_START: if (hi)   state_d = SUP_RUN;
            SUP_RUN:   if (trip) state_d = SUP_LATCH;
            SUP_LATCH: state_d = SUP_LATCH;
            default:   state_d = SUP_START;
        endcase
    end

    // arming on first lower-threshold crossing in regulation
    always_ff @(posedge clk) begin
        if (!rst_n || por)
            armed_q <= 1'b0;
        else if (state_q == SUP_RUN && lo)
            armed_q <= 1'b1;
    end

    // outputs
    always_comb begin
        in_run  = 1'b0;
        latched = 1'b0;
        unique case (state_q)
            SUP_START: ;
            SUP_RUN:   in_run  = 1'b1;
            SUP_LATCH: latched = 1'b1;
            default:   ;
        endcase
        run_en = in_run && !ot;
        armed  = armed_q;
    end
endmodule

// File: rtl/supply_fault_supervisor.sv
module supply_fault_supervisor #(
    parameter int FILT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_above_hi,
    input  logic vcc_below_lo,
    input  logic vcc_below_por,
    input  logic fb_open_loop,
    input  logic over_temp,
    output logic src_en,
    output logic run_en,
    output logic armed,
    output logic latched
);
    logic in_run;
    logic trip;

    sfs_source_hyst u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .por    (vcc_below_por),
        .hi     (vcc_above_hi),
        .lo     (vcc_below_lo),
        .src_en (src_en)
    );

    sfs_overload_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .por    (vcc_below_por),
        .enable (armed && in_run),
        .fb     (fb_open_loop),
        .hit    (trip)
    );

    sfs_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .por     (vcc_below_por),
        .hi      (vcc_above_hi),
        .lo      (vcc_below_lo),
        .trip    (trip),
        .ot      (over_temp),
        .run_en  (run_en),
        .armed   (armed),
        .latched (latched),
        .in_run  (in_run)
    );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker (
    input logic clk,
    input logic rst_n,
    input logic por,
    input logic hi,
    input logic lo,
    input logic ot,
    input logic src_en,
    input logic run_en,
    input logic armed,
    input logic latched
);
    // R2
    src_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi && !por) |=> !src_en);

    // R2
    src_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo && !hi && !por) |=> src_en);

    // R6
    trip_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> $past(armed));

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !por) |=> latched);

    // R7
    latch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latched |-> !run_en);

    // R8
    por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por |=> (src_en && !run_en && !armed && !latched));

    // R9
    hot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot |-> !run_en);
endmodule

bind supply_fault_supervisor sfs_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .por     (vcc_below_por),
    .hi      (vcc_above_hi),
    .lo      (vcc_below_lo),
    .ot      (over_temp),
    .src_en  (src_en),
    .run_en  (run_en),
    .armed   (armed),
    .latched (latched)
);

// File: tb/supply_fault_supervisor_test.sv
`timescale 1ns/1ps
module supply_fault_supervisor_test;
    localparam int FILT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 1'b0, lo = 1'b0, por = 1'b0, fb = 1'b0, ot = 1'b0;
    logic src_en, run_en, armed, latched;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    supply_fault_supervisor #(.FILT_CYCLES(FILT)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .vcc_above_hi  (hi),
        .vcc_below_lo  (lo),
        .vcc_below_por (por),
        .fb_open_loop  (fb),
        .over_temp     (ot),
        .src_en        (src_en),
        .run_en        (run_en),
        .armed         (armed),
        .latched       (latched)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic s, input logic r,
                           input logic a, input logic l);
        chk({tag, " src_en"}, src_en, s);
        chk({tag, " run_en"}, run_en, r);
        chk({tag, " armed"}, armed, a);
        chk({tag, " latched"}, latched, l);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        step();
        chk_all("R1 reset", 1, 0, 0, 0);
        rst_n = 1'b1;
        lo = 1'b1;
        fb = 1'b1;
        for (int i = 0; i < 3; i++) step();
        chk_all("R1 R5 start charging", 1, 0, 0, 0);

        // startup done
        lo = 1'b0; fb = 1'b0; hi = 1'b1;
        step();
        chk_all("R2 R3 first upper", 0, 1, 0, 0);
        hi = 1'b0;
        step();
        chk_all("R2 R4 hold off", 0, 1, 0, 0);

        // open loop before arming is ignored
        fb = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            chk("R5 unarmed latched", latched, 0);
            chk("R5 unarmed run_en", run_en, 1);
        end
        fb = 1'b0;

        // first descent arms
        lo = 1'b1;
        step();
        chk_all("R2 R4 R5 arm", 1, 1, 1, 0);
        lo = 1'b0;

        // burst length sweep
        for (int len = 1; len <= FILT; len++) begin
            fb = 1'b1;
            for (int i = 0; i < len; i++) begin
                step();
                chk("R6 burst latched", latched, (i + 1 >= FILT));
                chk("R6 R7 burst run_en", run_en, !(i + 1 >= FILT));
            end
            fb = 1'b0;
            step();
            chk("R6 after burst", latched, (len >= FILT));
        end

        // latched: source keeps cycling
        hi = 1'b1; fb = 1'b1;
        step();
        chk_all("R7 latched hi", 0, 0, 1, 1);
        hi = 1'b0; lo = 1'b1; fb = 1'b0;
        step();
        chk_all("R7 latched lo", 1, 0, 1, 1);
        hi = 1'b1;
        step();
        chk_all("R2 R7 both flags", 0, 0, 1, 1);

        // supply collapse, with simultaneous upper flag
        lo = 1'b0; por = 1'b1;
        step();
        chk_all("R8 por wins", 1, 0, 0, 0);
        por = 1'b0;
        step();
        chk_all("R3 R8 restart", 0, 1, 0, 0);
        hi = 1'b0;

        // over temperature
        ot = 1'b1;
        #1;
        chk("R9 same cycle", run_en, 0);
        step();
        chk_all("R9 held", 0, 0, 0, 0);
        ot = 1'b0;
        #1;
        chk("R9 release", run_en, 1);
        step();

        // hysteresis sweep from both prior states
        for (int prev = 0; prev < 2; prev++) begin
            for (int combo = 0; combo < 4; combo++) begin
                hi = (prev == 0); lo = (prev == 1);
                step();
                hi = combo[1]; lo = combo[0];
                step();
                chk("R2 sweep", src_en,
                    combo[1] ? 1'b0 : (combo[0] ? 1'b1 : prev[0]));
                chk("R4 sweep", run_en, 1);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule